// File: doc/BRIEF.md
# Per-Core Transactional Conflict Tracker

This block sits next to one core's private cache in a multicore system that runs hardware transactions. While a transaction runs, it marks each cache line the core reads or writes. It also keeps two per-core bit vectors. The first vector, called "racers" here, lists the cores this core must abort if it commits first. The second, called "killers", lists the cores whose commit would abort this one. Conflicts are classified the moment the directory reports that another core shares a marked line. They are not resolved until a commit happens.

When the core commits, the block sends one abort message per cycle to every racer, lowest core index first. It then waits until every one of those aborts has been acknowledged and reports completion with a one-cycle pulse. An abort from another core is always acknowledged. It ends the local transaction only when the sender is a recorded killer. Cores that touched disjoint lines record nothing against each other, so each of them commits in a single cycle with no messages.

Top module: `txn_conflict_tracker`

## Requirements
- R1: After reset, every output is zero and no transaction is active.
- R2: A remote read notification for a line that is only read locally, or any notification for a line with no local mark, changes neither vector.
- R3: A notification (note_write_i 0 = remote read, 1 = remote write) for a line written locally during the active transaction sets that core's bit in the racers vector.
- R4: A remote write notification for a line read or written locally sets that core's bit in the killers vector.
- R5: When a local access (acc_write_i 0 = read, 1 = write) and a notification hit the same line in the same cycle, the notification is classified as if the access had already been recorded.
- R6: A notification that names the block's own core index is ignored.
- R7: The cycle after a commit request, the block issues aborts one per cycle to each racer in ascending core index. With no racers, commit_done_o is high in the cycle after the request.
- R8: commit_done_o is a one-cycle pulse. It is never raised before every abort sent for that commit has been acknowledged, and never in the same cycle as an outgoing abort.
- R9: Every incoming abort is acknowledged in the following cycle with the sender's index. If the sender is in the killers vector of an active transaction, aborted_o pulses in that same cycle and the transaction ends.
- R10: An abort received while a commit is in progress is acknowledged but does not raise aborted_o, and the commit still completes.
- R11: A transaction begin clears every line mark and both vectors, including the state of a transaction that is still running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_begin_i | input | 1 | Start (or restart) a transaction |
| tx_commit_i | input | 1 | Request commit of the running transaction |
| acc_valid_i | input | 1 | Local cache access valid |
| acc_write_i | input | 1 | 1 = local write, 0 = local read |
| acc_line_i | input | LINE_W | Line index of the local access |
| note_valid_i | input | 1 | Directory sharing notification valid |
| note_write_i | input | 1 | 1 = remote core writes, 0 = remote core reads |
| note_core_i | input | CORE_W | Index of the remote core |
| note_line_i | input | LINE_W | Line index the notification refers to |
| abort_in_valid_i | input | 1 | Abort message received from another core |
| abort_in_core_i | input | CORE_W | Sender of the received abort |
| ack_in_valid_i | input | 1 | Acknowledgement of an abort this core sent |
| ack_in_core_i | input | CORE_W | Core returning the acknowledgement |
| abort_out_valid_o | output | 1 | Abort message issued to a racer |
| abort_out_core_o | output | CORE_W | Target core of the issued abort |
| ack_out_valid_o | output | 1 | Acknowledgement of a received abort |
| ack_out_core_o | output | CORE_W | Core the acknowledgement goes to |
| commit_done_o | output | 1 | One-cycle pulse: commit finished |
| aborted_o | output | 1 | One-cycle pulse: transaction aborted by a killer |

## Verification
Two pairs of functions can fall into the same cycle. The first is a local access and a directory notification on the same line. The bench provokes this by driving both on one clock for read/write mixes where the line had no earlier mark. It judges the outcome by the aborts a later commit emits and by whether a probe abort from the noted core ends the transaction. The second is an incoming abort from a killer that arrives while this core is already committing. The bench injects it in the cycle an outgoing abort is seen. It expects an acknowledgement, no aborted pulse, and a commit that still completes once its own acknowledgement returns.

// File: rtl/tx_tracker_pkg.sv
package tx_tracker_pkg;
  typedef enum logic [1:0] {
    TX_IDLE   = 2'd0,
    TX_ACTIVE = 2'd1,
    TX_COMMIT = 2'd2
  } tx_state_e;
endpackage

// File: rtl/tx_line_flags.sv
module tx_line_flags #(
  parameter int NUM_LINES = 16,
  localparam int LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              set_en_i,
  input  logic              set_wr_i,
  input  logic [LINE_W-1:0] set_line_i,
  input  logic [LINE_W-1:0] rd_line_i,
  output logic              rd_sr_o,
  output logic              rd_sm_o
);
  logic [NUM_LINES-1:0] rmark_q, wmark_q;
  logic                 same_line;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic hit, rd_d, wr_d, en;
    always_comb begin
      hit  = set_en_i && (set_line_i == LINE_W'(g));
      en   = clr_i || hit;
      rd_d = clr_i ? 1'b0 : (rmark_q[g] | ~set_wr_i);
      wr_d = clr_i ? 1'b0 : (wmark_q[g] |  set_wr_i);
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rmark_q[g] <= 1'b0;
        wmark_q[g] <= 1'b0;
      end else if (en) begin
        rmark_q[g] <= rd_d;
        wmark_q[g] <= wr_d;
      end
    end
  end

  // Forward a same-cycle access to the classification read port.
  always_comb begin
    same_line = set_en_i && (set_line_i == rd_line_i);
    rd_sr_o   = rmark_q[rd_line_i] | (same_line & ~set_wr_i);
    rd_sm_o   = wmark_q[rd_line_i] | (same_line &  set_wr_i);
  end

  // R11
  set_vs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_en_i |-> !clr_i);
endmodule

// File: rtl/tx_conflict_class.sv
module tx_conflict_class (
  input  logic note_valid_i,
  input  logic note_write_i,
  input  logic note_self_i,
  input  logic loc_sr_i,
  input  logic loc_sm_i,
  output logic set_racer_o,
  output logic set_killer_o
);
  logic shared;
  always_comb begin
    shared       = note_valid_i && !note_self_i && (loc_sr_i || loc_sm_i);
    // Local writer vs any remote access: remote core loses if we commit first.
    set_racer_o  = shared && loc_sm_i;
    // Remote writer vs any local mark: we lose if it commits first.
    set_killer_o = shared && note_write_i;
  end
endmodule

// File: rtl/tx_abort_seq.sv
module tx_abort_seq #(
  parameter int NUM_CORES = 8,
  localparam int CORE_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_i,
  input  logic [NUM_CORES-1:0] load_vec_i,
  input  logic                 ack_valid_i,
  input  logic [CORE_W-1:0]    ack_core_i,
  output logic                 abort_valid_o,
  output logic [CORE_W-1:0]    abort_core_o,
  output logic                 all_done_o
);
  logic [NUM_CORES-1:0] send_q, send_d, wait_q, wait_d;
  logic [NUM_CORES-1:0] pick_mask, ack_mask;
  logic [CORE_W-1:0]    pick_idx;
  logic                 pick_any, en;

  always_comb begin
    pick_idx = '0;
    for (int i = NUM_CORES - 1; i >= 0; i--) begin
      if (send_q[i]) pick_idx = CORE_W'(i);
    end
    pick_any  = |send_q;
    pick_mask = pick_any ? ({{(NUM_CORES-1){1'b0}}, 1'b1} << pick_idx) : '0;
    ack_mask  = ack_valid_i ? ({{(NUM_CORES-1){1'b0}}, 1'b1} << ack_core_i) : '0;
    send_d    = load_i ? load_vec_i : (send_q & ~pick_mask);
    wait_d    = load_i ? load_vec_i : (wait_q & ~ack_mask);
    en        = load_i || pick_any || ack_valid_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      send_q <= '0;
      wait_q <= '0;
    end else if (en) begin
      send_q <= send_d;
      wait_q <= wait_d;
    end
  end

  assign abort_valid_o = pick_any;
  assign abort_core_o  = pick_idx;
  assign all_done_o    = ~|send_q && ~|wait_q;

  // R7
  ascending_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_valid_o && $past(abort_valid_o)) |-> (abort_core_o > $past(abort_core_o)));
  // R8
  done_after_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
    all_done_o |-> !abort_valid_o);
endmodule

// File: rtl/txn_conflict_tracker.sv
module txn_conflict_tracker #(
  parameter int NUM_CORES = 8,
  parameter int NUM_LINES = 16,
  parameter int SELF_ID   = 0,
  localparam int CORE_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_begin_i,
  input  logic              tx_commit_i,
  input  logic              acc_valid_i,
  input  logic              acc_write_i,
  input  logic [LINE_W-1:0] acc_line_i,
  input  logic              note_valid_i,
  input  logic              note_write_i,
  input  logic [CORE_W-1:0] note_core_i,
  input  logic [LINE_W-1:0] note_line_i,
  input  logic              abort_in_valid_i,
  input  logic [CORE_W-1:0] abort_in_core_i,
  input  logic              ack_in_valid_i,
  input  logic [CORE_W-1:0] ack_in_core_i,
  output logic              abort_out_valid_o,
  output logic [CORE_W-1:0] abort_out_core_o,
  output logic              ack_out_valid_o,
  output logic [CORE_W-1:0] ack_out_core_o,
  output logic              commit_done_o,
  output logic              aborted_o
);
  import tx_tracker_pkg::*;

  tx_state_e            state_q, state_d;
  logic [NUM_CORES-1:0] racers_q, racers_d, killers_q, killers_d, note_mask;
  logic                 active, begin_go, abort_hit, commit_go, finish_go;
  logic                 flag_clr, acc_en, vec_en, note_self;
  logic                 loc_sr, loc_sm, set_racer, set_killer, seq_done;
  logic                 ack_q, aborted_q;
  logic [CORE_W-1:0]    ack_core_q;

  // Control decode: killer abort beats begin, begin beats commit.
  always_comb begin
    active    = (state_q == TX_ACTIVE);
    abort_hit = abort_in_valid_i && active && killers_q[abort_in_core_i];
    begin_go  = tx_begin_i && (state_q != TX_COMMIT) && !abort_hit;
    commit_go = tx_commit_i && active && !abort_hit && !begin_go;
    finish_go = (state_q == TX_COMMIT) && seq_done;
    flag_clr  = begin_go || abort_hit || finish_go;
    acc_en    = acc_valid_i && active && !flag_clr && !commit_go;
    vec_en    = active && !flag_clr;
    note_self = (note_core_i == CORE_W'(SELF_ID));
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      TX_IDLE:   if (begin_go) state_d = TX_ACTIVE;
      TX_ACTIVE: begin
        if (abort_hit)      state_d = TX_IDLE;
        else if (begin_go)  state_d = TX_ACTIVE;
        else if (commit_go) state_d = TX_COMMIT;
      end
      TX_COMMIT: if (seq_done) state_d = TX_IDLE;
      default:   state_d = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= TX_IDLE;
    else        state_q <= state_d;
  end

  tx_line_flags #(.NUM_LINES(NUM_LINES)) i_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (flag_clr),
    .set_en_i   (acc_en),
    .set_wr_i   (acc_write_i),
    .set_line_i (acc_line_i),
    .rd_line_i  (note_line_i),
    .rd_sr_o    (loc_sr),
    .rd_sm_o    (loc_sm)
  );

  tx_conflict_class i_class (
    .note_valid_i (note_valid_i && vec_en),
    .note_write_i (note_write_i),
    .note_self_i  (note_self),
    .loc_sr_i     (loc_sr),
    .loc_sm_i     (loc_sm),
    .set_racer_o  (set_racer),
    .set_killer_o (set_killer)
  );

  always_comb begin
    note_mask = {{(NUM_CORES-1){1'b0}}, 1'b1} << note_core_i;
    racers_d  = flag_clr ? '0 : (racers_q  | (set_racer  ? note_mask : '0));
    killers_d = flag_clr ? '0 : (killers_q | (set_killer ? note_mask : '0));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      racers_q  <= '0;
      killers_q <= '0;
    end else if (vec_en || flag_clr) begin
      racers_q  <= racers_d;
      killers_q <= killers_d;
    end
  end

  tx_abort_seq #(.NUM_CORES(NUM_CORES)) i_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .load_i        (commit_go),
    .load_vec_i    (racers_q),
    .ack_valid_i   (ack_in_valid_i),
    .ack_core_i    (ack_in_core_i),
    .abort_valid_o (abort_out_valid_o),
    .abort_core_o  (abort_out_core_o),
    .all_done_o    (seq_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q      <= 1'b0;
      ack_core_q <= '0;
      aborted_q  <= 1'b0;
    end else begin
      ack_q     <= abort_in_valid_i;
      aborted_q <= abort_hit;
      if (abort_in_valid_i) ack_core_q <= abort_in_core_i;
    end
  end

  assign ack_out_valid_o = ack_q;
  assign ack_out_core_o  = ack_core_q;
  assign aborted_o       = aborted_q;
  assign commit_done_o   = finish_go;

  // R9
  ack_follows_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_out_valid_o == $past(abort_in_valid_i));
  // R9
  ack_core_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_out_valid_o |-> ack_out_core_o == $past(abort_in_core_i));
  // R10
  abort_only_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    aborted_o |-> ($past(state_q) == TX_ACTIVE) && $past(abort_in_valid_i));
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_done_o |=> !commit_done_o);
  // R3
  racer_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(racers_q & ~$past(racers_q))) |-> $past(note_valid_i) && ($past(state_q) == TX_ACTIVE));
  // R4
  killer_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(killers_q & ~$past(killers_q))) |-> $past(note_valid_i && note_write_i));
  // R6
  no_self_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !racers_q[SELF_ID] && !killers_q[SELF_ID]);
endmodule

// File: tb/test_txn_conflict_tracker.sv
module test_txn_conflict_tracker;
  localparam int NC = 8;
  localparam int NL = 16;
  localparam int CW = 3;
  localparam int LW = 4;

  logic clk, rst_n;
  logic tx_begin_i, tx_commit_i, acc_valid_i, acc_write_i;
  logic [LW-1:0] acc_line_i, note_line_i;
  logic note_valid_i, note_write_i;
  logic [CW-1:0] note_core_i, abort_in_core_i, ack_in_core_i;
  logic abort_in_valid_i, ack_in_valid_i;
  logic abort_out_valid_o, ack_out_valid_o, commit_done_o, aborted_o;
  logic [CW-1:0] abort_out_core_o, ack_out_core_o;

  int errors = 0;
  int checks = 0;

  txn_conflict_tracker #(.NUM_CORES(NC), .NUM_LINES(NL), .SELF_ID(0)) i_txn_conflict_tracker (
    .clk(clk), .rst_n(rst_n), .tx_begin_i(tx_begin_i), .tx_commit_i(tx_commit_i),
    .acc_valid_i(acc_valid_i), .acc_write_i(acc_write_i), .acc_line_i(acc_line_i),
    .note_valid_i(note_valid_i), .note_write_i(note_write_i), .note_core_i(note_core_i),
    .note_line_i(note_line_i), .abort_in_valid_i(abort_in_valid_i),
    .abort_in_core_i(abort_in_core_i), .ack_in_valid_i(ack_in_valid_i),
    .ack_in_core_i(ack_in_core_i), .abort_out_valid_o(abort_out_valid_o),
    .abort_out_core_o(abort_out_core_o), .ack_out_valid_o(ack_out_valid_o),
    .ack_out_core_o(ack_out_core_o), .commit_done_o(commit_done_o), .aborted_o(aborted_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Vector: {local op (0 none,1 read,2 write), remote write, same cycle, exp racer, exp killer}
  localparam logic [5:0] TBL [8] = '{
    {2'd1, 1'b0, 1'b0, 1'b0, 1'b0},  // R2 read/read
    {2'd1, 1'b1, 1'b0, 1'b0, 1'b1},  // R4 local read, remote write
    {2'd2, 1'b0, 1'b0, 1'b1, 1'b0},  // R3 local write, remote read
    {2'd2, 1'b1, 1'b0, 1'b1, 1'b1},  // R3 R4 write/write
    {2'd0, 1'b1, 1'b0, 1'b0, 1'b0},  // R2 unmarked line
    {2'd1, 1'b1, 1'b1, 1'b0, 1'b1},  // R5 same cycle read vs write
    {2'd2, 1'b0, 1'b1, 1'b1, 1'b0},  // R5 same cycle write vs read
    {2'd1, 1'b0, 1'b1, 1'b0, 1'b0}   // R5 same cycle read/read
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    tx_begin_i = 0; tx_commit_i = 0; acc_valid_i = 0; acc_write_i = 0; acc_line_i = '0;
    note_valid_i = 0; note_write_i = 0; note_core_i = '0; note_line_i = '0;
    abort_in_valid_i = 0; abort_in_core_i = '0; ack_in_valid_i = 0; ack_in_core_i = '0;
  endtask

  task automatic do_begin();
    @(negedge clk); tx_begin_i = 1;
    @(negedge clk); tx_begin_i = 0;
  endtask

  task automatic do_access(input logic wr, input logic [LW-1:0] line);
    acc_valid_i = 1; acc_write_i = wr; acc_line_i = line;
    @(negedge clk); acc_valid_i = 0;
  endtask

  task automatic do_note(input logic wr, input logic [CW-1:0] core, input logic [LW-1:0] line);
    note_valid_i = 1; note_write_i = wr; note_core_i = core; note_line_i = line;
    @(negedge clk); note_valid_i = 0;
  endtask

  task automatic setup(input logic [1:0] lop, input logic rw, input logic same);
    do_begin();
    if (same) begin
      acc_valid_i = (lop != 0); acc_write_i = (lop == 2); acc_line_i = 4'd3;
      note_valid_i = 1; note_write_i = rw; note_core_i = 3'd2; note_line_i = 4'd3;
      @(negedge clk); acc_valid_i = 0; note_valid_i = 0;
    end else begin
      if (lop != 0) do_access(lop == 2, 4'd3);
      do_note(rw, 3'd2, 4'd3);
    end
  endtask

  // Commit, collect aborts, acknowledge, and check completion.
  task automatic run_commit(input logic [NC-1:0] exp, input string tag);
    int rec [NC];
    int n = 0;
    int k = 0;
    tx_commit_i = 1;
    @(negedge clk); tx_commit_i = 0;
    if (exp == 0) begin
      chk(commit_done_o === 1'b1, {tag, " R7 empty commit done"}, commit_done_o, 1);
      chk(abort_out_valid_o === 1'b0, {tag, " R7 no abort"}, abort_out_valid_o, 0);
      @(negedge clk);
      chk(commit_done_o === 1'b0, {tag, " R8 single pulse"}, commit_done_o, 0);
      return;
    end
    while (abort_out_valid_o === 1'b1 && n < NC) begin
      rec[n] = int'(abort_out_core_o);
      n++;
      if (commit_done_o !== 1'b0) chk(0, {tag, " R8 done during send"}, commit_done_o, 0);
      @(negedge clk);
    end
    for (int i = 0; i < NC; i++) begin
      if (exp[i]) begin
        chk(k < n && rec[k] == i, {tag, " R7 abort order"}, (k < n) ? rec[k] : -1, i);
        k++;
      end
    end
    chk(n == k, {tag, " R7 abort count"}, n, k);
    for (int i = 0; i < n; i++) begin
      chk(commit_done_o === 1'b0, {tag, " R8 wait for acks"}, commit_done_o, 0);
      ack_in_valid_i = 1; ack_in_core_i = CW'(rec[i]);
      @(negedge clk);
    end
    ack_in_valid_i = 0;
    chk(commit_done_o === 1'b1, {tag, " R8 done after acks"}, commit_done_o, 1);
    @(negedge clk);
    chk(commit_done_o === 1'b0, {tag, " R8 single pulse"}, commit_done_o, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk({abort_out_valid_o, ack_out_valid_o, commit_done_o, aborted_o} == 4'b0,
        "R1 reset outputs", {abort_out_valid_o, ack_out_valid_o, commit_done_o, aborted_o}, 0);

    for (int e = 0; e < 8; e++) begin
      logic [5:0] v;
      v = TBL[e];
      // racer side
      setup(v[5:4], v[3], v[2]);
      run_commit(v[1] ? 8'b0000_0100 : 8'b0, $sformatf("vec%0d R3", e));
      // killer side, probe with an abort from core 2
      setup(v[5:4], v[3], v[2]);
      abort_in_valid_i = 1; abort_in_core_i = 3'd2;
      @(negedge clk); abort_in_valid_i = 0;
      chk(ack_out_valid_o === 1'b1 && ack_out_core_o == 3'd2,
          $sformatf("vec%0d R9 ack", e), ack_out_core_o, 2);
      chk(aborted_o === v[0], $sformatf("vec%0d R4 R9 aborted", e), aborted_o, v[0]);
    end

    // R11: restart clears a recorded racer
    do_begin();
    do_access(1, 4'd3);
    do_note(0, 3'd2, 4'd3);
    do_begin();
    run_commit(8'b0, "R11 begin clears");

    // R6: notification naming own index
    do_begin();
    do_access(1, 4'd4);
    do_note(1, 3'd0, 4'd4);
    run_commit(8'b0, "R6 self ignored");

    // R7 R8: several racers noted out of order
    do_begin();
    do_access(1, 4'd1);
    do_note(0, 3'd6, 4'd1);
    do_note(0, 3'd2, 4'd1);
    do_note(1, 3'd5, 4'd1);
    run_commit(8'b0110_0100, "R7 multi racers");

    // R10: killer abort arriving during commit
    do_begin();
    do_access(1, 4'd7);
    do_note(1, 3'd5, 4'd7);
    tx_commit_i = 1;
    @(negedge clk); tx_commit_i = 0;
    chk(abort_out_valid_o === 1'b1 && abort_out_core_o == 3'd5, "R10 abort out",
        abort_out_core_o, 5);
    abort_in_valid_i = 1; abort_in_core_i = 3'd5;
    @(negedge clk); abort_in_valid_i = 0;
    chk(ack_out_valid_o === 1'b1 && ack_out_core_o == 3'd5, "R10 ack", ack_out_core_o, 5);
    chk(aborted_o === 1'b0, "R10 not aborted", aborted_o, 0);
    chk(commit_done_o === 1'b0, "R10 R8 still waiting", commit_done_o, 0);
    ack_in_valid_i = 1; ack_in_core_i = 3'd5;
    @(negedge clk); ack_in_valid_i = 0;
    chk(commit_done_o === 1'b1, "R10 commit completes", commit_done_o, 1);
    @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule